// File: doc/BRIEF.md
# Byte Compare Instruction Executor

This block decodes and runs the 8-bit compare instruction of a small CISC processor. Instruction words reach it one 16-bit word at a time over a valid/ready handshake. The block holds eight 32-bit general registers, and either byte of the low half of each register can be named as an operand. It subtracts the source byte from the destination byte and keeps only the condition flags. The block never writes the destination operand, memory, or any register that was not named as a pointer.

The destination can be a register byte or a memory byte. A memory byte is reached through a pointer register, which can be used unchanged or can step by one before or after the read. The source can be an 8-bit immediate or a register byte. Memory is reached through a read-only byte port with a valid/ready handshake. When the flags and any pointer update are committed, a one-cycle done pulse is raised. An encoding that is not recognised raises a one-cycle illegal pulse and returns the decoder to the first-word state.

Top module: `bcmp_exec`

## Requirements
- R1: After a synchronous reset, all flags are 0, done and illegal are low, iw_ready is high and every register reads 0.
- R2: The single word {4'hA, d, imm8} compares the register byte selected by nibble d against imm8.
- R3: The single word {8'h1C, s, d} compares the register byte selected by d against the register byte selected by s.
- R4: The flags port is {H,N,Z,V,C} for r = dst - src in 8 bits. C is the borrow out of bit 7, H is the borrow out of bit 3, V is two's-complement overflow, N is r[7] and Z is (r == 0).
- R5: In a byte-register nibble, bit 3 = 1 selects bits [7:0] of register nibble[2:0], and bit 3 = 0 selects bits [15:8].
- R6: The word {8'h7D, 0,p[2:0], 4'h0} is followed by {8'hA0, imm8} or {8'h1C, s, 4'h0}. It compares the memory byte at register p against the source and leaves p unchanged.
- R7: The prefix 16'h0174/0175/0176/0177 (post-increment, pre-increment, post-decrement, pre-decrement) is followed by {8'h6C, 0,p[2:0], 4'h8} and then {8'hA0, imm8}. It compares memory against the immediate.
- R8: The prefix 16'h0179 is followed by {m, 0,p[2:0], 4'h2, s}, where m is 8 for post-increment, 9 for pre-increment, A for post-decrement and B for pre-decrement. It compares memory against the register byte s.
- R9: Post modes read at the original pointer. Pre modes read at pointer ±1. In all four modes the pointer ends at its original value ±1.
- R10: A compare changes no register except the pointer in an auto-modified mode.
- R11: An unrecognised word gives a one-cycle illegal pulse, leaves the flags and registers unchanged, and restarts decoding at the next word.
- R12: done is high for exactly one cycle per compare. rd_addr holds steady while rd_valid is high and rd_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iw_valid | input | 1 | Instruction word valid |
| iw_data | input | 16 | Instruction word |
| iw_ready | output | 1 | Decoder accepts a word |
| rd_valid | output | 1 | Memory byte read request |
| rd_addr | output | 32 | Memory read address |
| rd_ready | input | 1 | Read accepted, rd_data valid |
| rd_data | input | 8 | Memory read byte |
| gpr_we | input | 1 | Register load strobe |
| gpr_wsel | input | 3 | Register to load |
| gpr_wdata | input | 32 | Register load value |
| gpr_rsel | input | 3 | Register to observe |
| gpr_rdata | output | 32 | Observed register value |
| flags | output | 5 | {H,N,Z,V,C} |
| done | output | 1 | Compare committed (one cycle) |
| illegal | output | 1 | Unrecognised encoding (one cycle) |

## Verification
The bench builds the block with its default parameters: eight registers of 32 bits each. With these values every pointer nibble and both byte halves of every register can be reached. A vector table drives the single-word immediate form across borrow, half-borrow, overflow and equality cases. Directed tests cover the indirect form and all eight auto-modified forms. The memory model places the match byte at one address only, so a wrong read address or a wrong final pointer value shows up in the flags or in the register readback. Memory stalls and illegal words are also exercised.

// File: rtl/bcmp_pkg.sv
package bcmp_pkg;
    localparam int REG_W = 32;
    localparam int NREG  = 8;
    localparam int SEL_W = $clog2(NREG);
    localparam logic [REG_W-1:0] STEP = REG_W'(1);

    // bit2: auto-modified pointer, bit1: decrement, bit0: pre-modify
    typedef enum logic [2:0] {
        AM_REG     = 3'd0,
        AM_IND     = 3'd1,
        AM_POSTINC = 3'd4,
        AM_PREINC  = 3'd5,
        AM_POSTDEC = 3'd6,
        AM_PREDEC  = 3'd7
    } amode_t;

    typedef enum logic [2:0] {
        S_W1, S_W2I, S_W2P, S_W2R, S_W3, S_MEM, S_EXEC
    } st_t;

    typedef struct packed {
        logic h;
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

    function automatic amode_t auto_mode(input logic [1:0] code);
        return amode_t'({1'b1, code});
    endfunction

    function automatic flags_t sub_flags(input logic [7:0] d, input logic [7:0] s);
        flags_t f;
        logic [8:0] full;
        logic [4:0] half;
        full = {1'b0, d} - {1'b0, s};
        half = {1'b0, d[3:0]} - {1'b0, s[3:0]};
        f.c  = full[8];
        f.h  = half[4];
        f.n  = full[7];
        f.z  = (full[7:0] == 8'h00);
        f.v  = (d[7] != s[7]) && (full[7] != d[7]);
        return f;
    endfunction
endpackage

// File: rtl/bcmp_regfile.sv
module bcmp_regfile
    import bcmp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ext_we,
    input  logic [SEL_W-1:0] ext_sel,
    input  logic [REG_W-1:0] ext_data,
    input  logic             ptr_we,
    input  logic [SEL_W-1:0] ptr_sel,
    input  logic [REG_W-1:0] ptr_wdata,
    input  logic [SEL_W:0]   dst_nib,
    input  logic [SEL_W:0]   src_nib,
    input  logic [SEL_W-1:0] obs_sel,
    output logic [REG_W-1:0] ptr_rdata,
    output logic [REG_W-1:0] obs_rdata,
    output logic [7:0]       dst_byte,
    output logic [7:0]       src_byte
);
    logic [REG_W-1:0] rf [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                rf[i] <= '0;
            else if (ptr_we && ptr_sel == SEL_W'(i))
                rf[i] <= ptr_wdata;
            else if (ext_we && ext_sel == SEL_W'(i))
                rf[i] <= ext_data;
        end

        // R10
        reg_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (!(ptr_we && ptr_sel == SEL_W'(i)) && !(ext_we && ext_sel == SEL_W'(i)))
            |=> $stable(rf[i]));
    end

    assign ptr_rdata = rf[ptr_sel];
    assign obs_rdata = rf[obs_sel];
    assign dst_byte  = dst_nib[SEL_W] ? rf[dst_nib[SEL_W-1:0]][7:0]
                                      : rf[dst_nib[SEL_W-1:0]][15:8];
    assign src_byte  = src_nib[SEL_W] ? rf[src_nib[SEL_W-1:0]][7:0]
                                      : rf[src_nib[SEL_W-1:0]][15:8];
endmodule

// File: rtl/bcmp_ctrl.sv
module bcmp_ctrl
    import bcmp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             iw_valid,
    input  logic [15:0]      iw_data,
    output logic             iw_ready,
    output logic             rd_valid,
    output logic [REG_W-1:0] rd_addr,
    input  logic             rd_ready,
    input  logic [7:0]       rd_data,
    input  logic [REG_W-1:0] ptr_val,
    output logic [SEL_W-1:0] ptr_sel,
    output logic             ptr_we,
    output logic [REG_W-1:0] ptr_new,
    output logic [SEL_W:0]   dst_nib,
    output logic [SEL_W:0]   src_nib,
    output logic             use_imm,
    output logic             use_mem,
    output logic [7:0]       imm,
    output logic [7:0]       mem_byte,
    output logic             exec,
    output logic             illegal
);
    st_t    st;
    amode_t mode;
    logic [15:0] w;
    assign w = iw_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= S_W1; mode <= AM_REG; ptr_sel <= '0;
            dst_nib <= '0; src_nib <= '0; imm <= '0; mem_byte <= '0;
            use_imm <= 1'b0; use_mem <= 1'b0; illegal <= 1'b0;
        end else begin
            illegal <= 1'b0;
            case (st)
                S_W1: if (iw_valid) begin
                    if (w[15:12] == 4'hA) begin
                        dst_nib <= w[11:8]; imm <= w[7:0];
                        use_imm <= 1'b1; use_mem <= 1'b0; mode <= AM_REG; st <= S_EXEC;
                    end else if (w[15:8] == 8'h1C) begin
                        src_nib <= w[7:4]; dst_nib <= w[3:0];
                        use_imm <= 1'b0; use_mem <= 1'b0; mode <= AM_REG; st <= S_EXEC;
                    end else if (w[15:8] == 8'h7D && !w[7] && w[3:0] == 4'h0) begin
                        ptr_sel <= w[6:4]; mode <= AM_IND; use_mem <= 1'b1; st <= S_W2I;
                    end else if (w[15:2] == 14'b0000_0001_0111_01) begin
                        mode <= auto_mode(w[1:0]); use_mem <= 1'b1; use_imm <= 1'b1;
                        st <= S_W2P;
                    end else if (w == 16'h0179) begin
                        use_mem <= 1'b1; use_imm <= 1'b0; st <= S_W2R;
                    end else begin
                        illegal <= 1'b1;
                    end
                end
                S_W2I: if (iw_valid) begin
                    if (w[15:8] == 8'hA0) begin
                        imm <= w[7:0]; use_imm <= 1'b1; st <= S_MEM;
                    end else if (w[15:8] == 8'h1C && w[3:0] == 4'h0) begin
                        src_nib <= w[7:4]; use_imm <= 1'b0; st <= S_MEM;
                    end else begin
                        illegal <= 1'b1; st <= S_W1;
                    end
                end
                S_W2P: if (iw_valid) begin
                    if (w[15:8] == 8'h6C && !w[7] && w[3:0] == 4'h8) begin
                        ptr_sel <= w[6:4]; st <= S_W3;
                    end else begin
                        illegal <= 1'b1; st <= S_W1;
                    end
                end
                S_W3: if (iw_valid) begin
                    if (w[15:8] == 8'hA0) begin
                        imm <= w[7:0]; st <= S_MEM;
                    end else begin
                        illegal <= 1'b1; st <= S_W1;
                    end
                end
                S_W2R: if (iw_valid) begin
                    if (w[15:14] == 2'b10 && !w[11] && w[7:4] == 4'h2) begin
                        mode <= auto_mode(w[13:12]); ptr_sel <= w[10:8];
                        src_nib <= w[3:0]; st <= S_MEM;
                    end else begin
                        illegal <= 1'b1; st <= S_W1;
                    end
                end
                S_MEM: if (rd_ready) begin
                    mem_byte <= rd_data; st <= S_EXEC;
                end
                default: st <= S_W1;
            endcase
        end
    end

    always_comb begin
        ptr_new = ptr_val;
        if (mode[2]) ptr_new = mode[1] ? ptr_val - STEP : ptr_val + STEP;
    end

    assign rd_addr  = (mode[2] && mode[0]) ? ptr_new : ptr_val;
    assign rd_valid = (st == S_MEM);
    assign exec     = (st == S_EXEC);
    assign ptr_we   = exec && mode[2];
    assign iw_ready = (st == S_W1) || (st == S_W2I) || (st == S_W2P) ||
                      (st == S_W2R) || (st == S_W3);

    // R12
    rd_addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));

    // R12
    no_fetch_during_read_chk: assert property (@(posedge clk) disable iff (rst)
        !(rd_valid && iw_ready));
endmodule

// File: rtl/bcmp_exec.sv
module bcmp_exec
    import bcmp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             iw_valid,
    input  logic [15:0]      iw_data,
    output logic             iw_ready,
    output logic             rd_valid,
    output logic [REG_W-1:0] rd_addr,
    input  logic             rd_ready,
    input  logic [7:0]       rd_data,
    input  logic             gpr_we,
    input  logic [SEL_W-1:0] gpr_wsel,
    input  logic [REG_W-1:0] gpr_wdata,
    input  logic [SEL_W-1:0] gpr_rsel,
    output logic [REG_W-1:0] gpr_rdata,
    output logic [4:0]       flags,
    output logic             done,
    output logic             illegal
);
    logic [REG_W-1:0] ptr_val, ptr_new;
    logic [SEL_W-1:0] ptr_sel;
    logic [SEL_W:0]   dst_nib, src_nib;
    logic [7:0]       imm, mem_byte, dst_rb, src_rb, dst_op, src_op;
    logic             ptr_we, use_imm, use_mem, exec;
    flags_t           flg_q, flg_d;

    bcmp_ctrl u_ctrl (
        .clk(clk), .rst(rst), .iw_valid(iw_valid), .iw_data(iw_data),
        .iw_ready(iw_ready), .rd_valid(rd_valid), .rd_addr(rd_addr),
        .rd_ready(rd_ready), .rd_data(rd_data), .ptr_val(ptr_val),
        .ptr_sel(ptr_sel), .ptr_we(ptr_we), .ptr_new(ptr_new),
        .dst_nib(dst_nib), .src_nib(src_nib), .use_imm(use_imm),
        .use_mem(use_mem), .imm(imm), .mem_byte(mem_byte), .exec(exec),
        .illegal(illegal)
    );

    bcmp_regfile u_rf (
        .clk(clk), .rst(rst), .ext_we(gpr_we), .ext_sel(gpr_wsel),
        .ext_data(gpr_wdata), .ptr_we(ptr_we), .ptr_sel(ptr_sel),
        .ptr_wdata(ptr_new), .dst_nib(dst_nib), .src_nib(src_nib),
        .obs_sel(gpr_rsel), .ptr_rdata(ptr_val), .obs_rdata(gpr_rdata),
        .dst_byte(dst_rb), .src_byte(src_rb)
    );

    assign dst_op = use_mem ? mem_byte : dst_rb;
    assign src_op = use_imm ? imm : src_rb;
    assign flg_d  = sub_flags(dst_op, src_op);

    always_ff @(posedge clk) begin
        if (rst) begin
            flg_q <= '0;
            done  <= 1'b0;
        end else begin
            done <= exec;
            if (exec) flg_q <= flg_d;
        end
    end

    assign flags = flg_q;

    // R11
    done_illegal_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(done && illegal));

    // R12
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R4
    zero_no_borrow_chk: assert property (@(posedge clk) disable iff (rst)
        flg_q.z |-> (!flg_q.c && !flg_q.h && !flg_q.n && !flg_q.v));

    // R11
    flags_hold_on_illegal_chk: assert property (@(posedge clk) disable iff (rst)
        illegal |-> $stable(flg_q));
endmodule

// File: tb/bcmp_exec_bench.sv
module bcmp_exec_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        iw_valid = 1'b0;
    logic [15:0] iw_data = 16'h0;
    logic        iw_ready, rd_valid, rd_ready, done, illegal;
    logic [31:0] rd_addr, gpr_rdata;
    logic [7:0]  rd_data;
    logic        gpr_we = 1'b0;
    logic [2:0]  gpr_wsel = 3'd0, gpr_rsel = 3'd0;
    logic [31:0] gpr_wdata = 32'h0;
    logic [4:0]  flags;
    logic        stall = 1'b0, gate = 1'b1;
    int          n_chk = 0, n_fail = 0, cyc = 0;

    always #5 clk = ~clk;

    bcmp_exec u_bcmp_exec (
        .clk(clk), .rst(rst), .iw_valid(iw_valid), .iw_data(iw_data),
        .iw_ready(iw_ready), .rd_valid(rd_valid), .rd_addr(rd_addr),
        .rd_ready(rd_ready), .rd_data(rd_data), .gpr_we(gpr_we),
        .gpr_wsel(gpr_wsel), .gpr_wdata(gpr_wdata), .gpr_rsel(gpr_rsel),
        .gpr_rdata(gpr_rdata), .flags(flags), .done(done), .illegal(illegal)
    );

    // memory: 0xA5 at 0x40 only, elsewhere the low address byte
    assign rd_data  = (rd_addr[7:0] == 8'h40) ? 8'hA5 : rd_addr[7:0];
    assign rd_ready = rd_valid & gate;
    always @(negedge clk) gate <= stall ? ~gate : 1'b1;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 50000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: act=%0d cycles exp=<50000", cyc);
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // {H,N,Z,V,C}
    function automatic logic [4:0] expf(input logic [7:0] d, input logic [7:0] s);
        int sd;
        logic [7:0] r;
        sd = int'($signed(d)) - int'($signed(s));
        r  = d - s;
        return {d[3:0] < s[3:0], r[7], d == s, (sd > 127) || (sd < -128), d < s};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wreg(input logic [2:0] i, input logic [31:0] v);
        @(negedge clk); gpr_we = 1'b1; gpr_wsel = i; gpr_wdata = v;
        @(negedge clk); gpr_we = 1'b0;
    endtask

    task automatic chk_reg(input string tag, input logic [2:0] i, input logic [31:0] exp);
        gpr_rsel = i; #1;
        chk(tag, gpr_rdata, exp);
    endtask

    task automatic send(input logic [15:0] wd);
        while (!iw_ready) @(negedge clk);
        iw_valid = 1'b1; iw_data = wd;
        @(negedge clk);
        iw_valid = 1'b0;
    endtask

    // returns 1 for done, 2 for illegal, 0 on timeout
    task automatic wait_end(output int how);
        how = 0;
        for (int k = 0; k < 100; k++) begin
            if (done)    begin how = 1; break; end
            if (illegal) begin how = 2; break; end
            @(negedge clk);
        end
    endtask

    task automatic run(input string tag, input logic [4:0] ef);
        int how;
        wait_end(how);
        chk({tag, " end"}, how, 1);
        chk({tag, " flags"}, {27'h0, flags}, {27'h0, ef});
    endtask

    localparam logic [15:0] VEC [8] = '{16'h0001, 16'h8001, 16'h7FFF, 16'h1001,
                                         16'hA5A4, 16'hA5A6, 16'hA5A5, 16'hFF00};

    initial begin
        int how;
        logic [4:0] keep;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk("R1 flags", {27'h0, flags}, 32'h0);
        chk("R1 done/illegal", {30'h0, done, illegal}, 32'h0);
        chk("R1 iw_ready", {31'h0, iw_ready}, 32'h1);
        chk_reg("R1 reg5", 3'd5, 32'h0);

        // R2 R4: immediate against r2 low byte (nibble A)
        for (int i = 0; i < 8; i++) begin
            wreg(3'd2, {24'hA5A5A5, VEC[i][15:8]});
            send({8'hAA, VEC[i][7:0]});
            run($sformatf("R2 R4 vec%0d", i), expf(VEC[i][15:8], VEC[i][7:0]));
        end
        chk_reg("R10 r2 after imm", 3'd2, 32'hA5A5A5FF);

        // R5: high byte of r3 (nibble 3)
        wreg(3'd3, 32'h1234A511);
        send(16'hA3A4); run("R5 high byte ne", expf(8'hA5, 8'hA4));
        send(16'hA3A5); run("R5 high byte eq", 5'b00100);
        send(16'hABA5); run("R5 low byte", expf(8'h11, 8'hA5));

        // R3: r1h (nibble 1) source, r1l (nibble 9) destination
        wreg(3'd1, 32'h0000A6A5);
        send(16'h1C19); run("R3 reg-reg lt", expf(8'hA5, 8'hA6));
        chk("R3 N^V", {31'h0, flags[3] ^ flags[1]}, 32'h1);
        chk_reg("R10 r1 after reg-reg", 3'd1, 32'h0000A6A5);

        // R6: indirect through r0
        wreg(3'd0, 32'h40);
        send(16'h7D00); send(16'hA0A5); run("R6 ind imm", 5'b00100);
        wreg(3'd1, 32'h0000A6A4);
        send(16'h7D00); send(16'h1C90); run("R6 ind reg", expf(8'hA5, 8'hA4));
        send(16'h7D00); send(16'h1C10); run("R6 ind reg hi", expf(8'hA5, 8'hA6));
        chk_reg("R6 ptr kept", 3'd0, 32'h40);

        // R7 R9: immediate prefixed modes
        wreg(3'd0, 32'h40);
        send(16'h0174); send(16'h6C08); send(16'hA0A5); run("R7 postinc", 5'b00100);
        chk_reg("R9 postinc ptr", 3'd0, 32'h41);
        wreg(3'd0, 32'h3F);
        send(16'h0175); send(16'h6C08); send(16'hA0A5); run("R7 preinc", 5'b00100);
        chk_reg("R9 preinc ptr", 3'd0, 32'h40);
        wreg(3'd0, 32'h40);
        send(16'h0176); send(16'h6C08); send(16'hA0A5); run("R7 postdec", 5'b00100);
        chk_reg("R9 postdec ptr", 3'd0, 32'h3F);
        wreg(3'd0, 32'h41);
        send(16'h0177); send(16'h6C08); send(16'hA0A5); run("R7 predec", 5'b00100);
        chk_reg("R9 predec ptr", 3'd0, 32'h40);

        // R8 R9 R12: register prefixed modes via r4, source r1l (0xA4), memory stalls
        stall = 1'b1;
        wreg(3'd4, 32'h40);
        send(16'h0179); send(16'h8429); run("R8 postinc", expf(8'hA5, 8'hA4));
        chk_reg("R9 r4 postinc", 3'd4, 32'h41);
        wreg(3'd4, 32'h3F);
        send(16'h0179); send(16'h9429); run("R8 preinc", expf(8'hA5, 8'hA4));
        chk_reg("R9 r4 preinc", 3'd4, 32'h40);
        wreg(3'd4, 32'h40);
        send(16'h0179); send(16'hA429); run("R8 postdec", expf(8'hA5, 8'hA4));
        chk_reg("R9 r4 postdec", 3'd4, 32'h3F);
        wreg(3'd4, 32'h41);
        send(16'h0179); send(16'hB429); run("R8 predec", expf(8'hA5, 8'hA4));
        chk_reg("R9 r4 predec", 3'd4, 32'h40);
        @(negedge clk);
        chk("R12 done one cycle", {31'h0, done}, 32'h0);
        stall = 1'b0;
        chk_reg("R10 r1 kept", 3'd1, 32'h0000A6A4);
        chk_reg("R10 r0 kept", 3'd0, 32'h40);
        chk_reg("R10 r3 kept", 3'd3, 32'h1234A511);

        // R11: illegal words
        send(16'hA3A5); run("R11 setup", 5'b00100);
        keep = flags;
        send(16'hFFFF); wait_end(how);
        chk("R11 bad first word", how, 2);
        @(negedge clk);
        chk("R11 illegal one cycle", {31'h0, illegal}, 32'h0);
        send(16'h7D08); wait_end(how);
        chk("R11 bad indirect word", how, 2);
        send(16'h0179); send(16'hC429); wait_end(how);
        chk("R11 bad mode nibble", how, 2);
        chk("R11 flags kept", {27'h0, flags}, {27'h0, keep});
        chk_reg("R11 r4 kept", 3'd4, 32'h40);
        send(16'hA3A4); run("R11 recover", expf(8'hA5, 8'hA4));

        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule